// File: doc/BRIEF.md
# Busy-Gated Trigger with Dead-Time Scalers

This block takes trigger requests from several independent sources and turns them into a single live trigger. A live trigger is only issued when the block is idle and none of the partner acquisition systems is raising its busy line. Each accepted trigger puts the block into its own busy state. That state lasts until a clear-busy pulse arrives. A clear-module pulse returns the whole block to its starting condition.

One veto condition gates several things at once: the live trigger, a divided time-stamp clock and a reference pulser. The veto is the internal busy state ORed with every partner busy line. Scalers count the raw triggers, the live triggers, each source, and the free-running and vetoed pulsers. Software can then compute dead time as one minus the vetoed pulser count divided by the free pulser count. A configuration input replaces the internally divided time-stamp clock with an external clock. The external clock is held by the same veto.

The control path is a two-state machine. In `ST_IDLE` the veto comes only from partner busy lines. The transition *accept* (a source edge while no partner is busy) issues the live trigger and moves to `ST_BUSY` on the same clock edge. In `ST_BUSY` every source edge is counted as raw but rejected. The transition *release* (a clear-busy edge) returns to `ST_IDLE`. The transition *abort* (clear-module) forces `ST_IDLE` from either state.

Top module: `trig_gate_top`

## Requirements
- R1: `live_trig_o` pulses for one cycle only when a source rising edge is seen while `busy_o` is low and every `busy_i` line is low. `raw_trig_o` pulses for every source rising edge, whatever the veto.
- R2: The edge that raises `live_trig_o` also raises `busy_o`, so a second source edge before a clear-busy is counted as raw and never gives a live trigger.
- R3: A rising edge on `clr_busy_i` drops `busy_o`. If it coincides with a source edge while busy, the clear wins and the trigger is rejected.
- R4: While the synchronized `clr_mod_i` is high, the state returns to idle and all scalers, dividers and pulsers are cleared.
- R5: With no veto and internal source selected (`ts_sel_ext_i`=0), `ts_clk_o` has a period of `TS_DIV` system clocks with equal high and low halves. While vetoed, it holds its level with no partial pulse.
- R6: With `ts_sel_ext_i`=1, `ts_clk_o` follows `ts_ext_i` three system clocks later. It also holds its level while vetoed.
- R7: `pulse_free_o` gives a one-cycle pulse every `PULSE_DIV` cycles. `pulse_veto_o` gives the same pulse only when the veto is low.
- R8: Each scaler adds one per input pulse, however long the input stays high. `cnt_src_o` slice i (bits i*CNT_W up to i*CNT_W+CNT_W-1) counts source i.
- R9: Scalers saturate at all ones instead of wrapping.
- R10: `scaler_clr_i` high at a clock edge clears every scaler together on that edge.
- R11: Any one of the `N_BUSY` partner busy lines on its own vetoes live triggers, the pulser and the time-stamp clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (divided for time stamps and pulser) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_mod_i | input | 1 | Asynchronous clear-module request |
| src_i | input | N_SRC | Asynchronous trigger sources (primary, secondary, two external) |
| busy_i | input | N_BUSY | Asynchronous partner busy levels |
| clr_busy_i | input | 1 | Asynchronous clear-busy pulse |
| ts_ext_i | input | 1 | External time-stamp clock |
| ts_sel_ext_i | input | 1 | 1 selects the external time-stamp clock |
| scaler_clr_i | input | 1 | Synchronous clear of all scalers |
| raw_trig_o | output | 1 | Raw trigger pulse |
| live_trig_o | output | 1 | Live trigger pulse |
| busy_o | output | 1 | Internal busy state |
| ts_clk_o | output | 1 | Vetoed time-stamp clock |
| pulse_free_o | output | 1 | Free-running pulser |
| pulse_veto_o | output | 1 | Vetoed pulser |
| cnt_src_o | output | N_SRC*CNT_W | Per-source scalers, packed |
| cnt_raw_o | output | CNT_W | Raw trigger scaler |
| cnt_live_o | output | CNT_W | Live trigger scaler |
| cnt_pfree_o | output | CNT_W | Free pulser scaler |
| cnt_pveto_o | output | CNT_W | Vetoed pulser scaler |

## Verification
The hardest case to reach is a clear-busy edge and a new source edge arriving on the very same clock while the block is busy. This only happens when both asynchronous inputs leave their synchronizers together. The stimulus drives both pins on the same falling edge, so that they cross the equal-depth synchronizers in lockstep. The bench then checks that no live trigger appears for that raw pulse and that `busy_o` ends low. Saturation is reached by building the bench with narrow scalers and firing more source pulses than they can hold while a partner holds busy.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } gate_state_e;

    typedef enum logic {
        TS_INTERNAL = 1'b0,
        TS_EXTERNAL = 1'b1
    } ts_src_e;
endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_i[b]};
            end
            assign level_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tg_gate_fsm.sv
module tg_gate_fsm
    import tgate_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int N_BUSY = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_mod,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic [N_BUSY-1:0] busy_lvl,
    input  logic              clr_busy_lvl,
    output logic [N_SRC-1:0]  src_rise,
    output logic              raw_trig_o,
    output logic              live_trig_o,
    output logic              busy_o,
    output logic              veto_o
);
    gate_state_e      state, state_nxt;
    logic [N_SRC-1:0] src_prev;
    logic             clr_prev;
    logic             clr_rise, any_rise, partner_busy, accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= '0;
            clr_prev <= 1'b0;
        end else begin
            src_prev <= src_lvl;
            clr_prev <= clr_busy_lvl;
        end
    end

    assign src_rise     = src_lvl & ~src_prev;
    assign clr_rise     = clr_busy_lvl & ~clr_prev;
    assign any_rise     = |src_rise;
    assign partner_busy = |busy_lvl;
    assign accept       = (state == ST_IDLE) && any_rise && !partner_busy;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nxt = ST_BUSY;
            ST_BUSY: if (clr_rise) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= ST_IDLE;
        else if (clr_mod) state <= ST_IDLE;
        else              state <= state_nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_trig_o  <= 1'b0;
            live_trig_o <= 1'b0;
        end else if (clr_mod) begin
            raw_trig_o  <= 1'b0;
            live_trig_o <= 1'b0;
        end else begin
            raw_trig_o  <= any_rise;
            live_trig_o <= accept;
        end
    end

    assign busy_o = (state == ST_BUSY);
    assign veto_o = busy_o | partner_busy;

    assert_live_needs_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig_o |-> $past(!veto_o) && raw_trig_o);
    assert_busy_with_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig_o |-> busy_o);
    assert_clear_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && busy_o) |=> !busy_o);
    assert_partner_veto_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (partner_busy && !clr_mod) |=> !live_trig_o);
endmodule

// File: rtl/tg_tsclk.sv
module tg_tsclk
    import tgate_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic veto,
    input  logic sel_ext,
    input  logic ext_lvl,
    output logic ts_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt;
    logic          phase;
    ts_src_e       src;

    assign phase = (cnt >= HALF);
    assign src   = ts_src_e'(sel_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            ts_o <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            ts_o <= 1'b0;
        end else if (!veto) begin
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            unique case (src)
                TS_INTERNAL: ts_o <= phase;
                TS_EXTERNAL: ts_o <= ext_lvl;
                default:     ts_o <= phase;
            endcase
        end
    end

    assert_ts_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (veto && !clr) |=> $stable(ts_o));
endmodule

// File: rtl/tg_pulser.sv
module tg_pulser #(
    parameter int DIV = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic veto,
    output logic free_o,
    output logic vetoed_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            free_o   <= 1'b0;
            vetoed_o <= 1'b0;
        end else if (clr) begin
            cnt      <= '0;
            free_o   <= 1'b0;
            vetoed_o <= 1'b0;
        end else begin
            cnt      <= tick ? '0 : cnt + 1'b1;
            free_o   <= tick;
            vetoed_o <= tick && !veto;
        end
    end

    assert_vetoed_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vetoed_o |-> free_o);
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |=> !free_o);
endmodule

// File: rtl/tg_scaler.sv
module tg_scaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= '0;
        else if (inc && q != FULL)  q <= q + 1'b1;
    end

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q == FULL && !clr) |=> q == FULL);
    assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && q != FULL) |=> (q == $past(q)) || (q == $past(q) + 1'b1));
endmodule

// File: rtl/trig_gate_top.sv
module trig_gate_top #(
    parameter int N_SRC     = 4,
    parameter int N_BUSY    = 5,
    parameter int CNT_W     = 32,
    parameter int TS_DIV    = 4,
    parameter int PULSE_DIV = 4000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_mod_i,
    input  logic [N_SRC-1:0]       src_i,
    input  logic [N_BUSY-1:0]      busy_i,
    input  logic                   clr_busy_i,
    input  logic                   ts_ext_i,
    input  logic                   ts_sel_ext_i,
    input  logic                   scaler_clr_i,
    output logic                   raw_trig_o,
    output logic                   live_trig_o,
    output logic                   busy_o,
    output logic                   ts_clk_o,
    output logic                   pulse_free_o,
    output logic                   pulse_veto_o,
    output logic [N_SRC*CNT_W-1:0] cnt_src_o,
    output logic [CNT_W-1:0]       cnt_raw_o,
    output logic [CNT_W-1:0]       cnt_live_o,
    output logic [CNT_W-1:0]       cnt_pfree_o,
    output logic [CNT_W-1:0]       cnt_pveto_o
);
    localparam int N_ASYNC = N_SRC + N_BUSY + 3;

    logic [N_ASYNC-1:0] async_lvl;
    logic [N_SRC-1:0]   src_lvl, src_rise;
    logic [N_BUSY-1:0]  busy_lvl;
    logic               clr_busy_lvl, clr_mod_lvl, ext_lvl;
    logic               veto, sc_clr;

    tg_sync #(.W(N_ASYNC), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ts_ext_i, clr_mod_i, clr_busy_i, busy_i, src_i}),
        .level_o (async_lvl)
    );

    assign src_lvl      = async_lvl[N_SRC-1:0];
    assign busy_lvl     = async_lvl[N_SRC +: N_BUSY];
    assign clr_busy_lvl = async_lvl[N_SRC+N_BUSY];
    assign clr_mod_lvl  = async_lvl[N_SRC+N_BUSY+1];
    assign ext_lvl      = async_lvl[N_SRC+N_BUSY+2];
    assign sc_clr       = scaler_clr_i | clr_mod_lvl;

    tg_gate_fsm #(.N_SRC(N_SRC), .N_BUSY(N_BUSY)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_mod      (clr_mod_lvl),
        .src_lvl      (src_lvl),
        .busy_lvl     (busy_lvl),
        .clr_busy_lvl (clr_busy_lvl),
        .src_rise     (src_rise),
        .raw_trig_o   (raw_trig_o),
        .live_trig_o  (live_trig_o),
        .busy_o       (busy_o),
        .veto_o       (veto)
    );

    tg_tsclk #(.DIV(TS_DIV)) u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_mod_lvl),
        .veto    (veto),
        .sel_ext (ts_sel_ext_i),
        .ext_lvl (ext_lvl),
        .ts_o    (ts_clk_o)
    );

    tg_pulser #(.DIV(PULSE_DIV)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_mod_lvl),
        .veto     (veto),
        .free_o   (pulse_free_o),
        .vetoed_o (pulse_veto_o)
    );

    genvar s;
    generate
        for (s = 0; s < N_SRC; s++) begin : g_src_sc
            tg_scaler #(.W(CNT_W)) u_sc (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sc_clr),
                .inc   (src_rise[s]),
                .q     (cnt_src_o[s*CNT_W +: CNT_W])
            );
        end
    endgenerate

    tg_scaler #(.W(CNT_W)) u_sc_raw (
        .clk(clk), .rst_n(rst_n), .clr(sc_clr), .inc(raw_trig_o), .q(cnt_raw_o));
    tg_scaler #(.W(CNT_W)) u_sc_live (
        .clk(clk), .rst_n(rst_n), .clr(sc_clr), .inc(live_trig_o), .q(cnt_live_o));
    tg_scaler #(.W(CNT_W)) u_sc_pfree (
        .clk(clk), .rst_n(rst_n), .clr(sc_clr), .inc(pulse_free_o), .q(cnt_pfree_o));
    tg_scaler #(.W(CNT_W)) u_sc_pveto (
        .clk(clk), .rst_n(rst_n), .clr(sc_clr), .inc(pulse_veto_o), .q(cnt_pveto_o));

    assert_live_counted_as_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig_o |-> raw_trig_o);
    assert_clear_scalers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scaler_clr_i |=> (cnt_raw_o == '0) && (cnt_live_o == '0) && (cnt_pfree_o == '0));
    assert_module_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mod_lvl |=> !busy_o && (cnt_live_o == '0));
endmodule

// File: tb/test_trig_gate_top.sv
module test_trig_gate_top;
    localparam int NS = 4;
    localparam int NB = 5;
    localparam int W  = 8;
    localparam int PD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_mod_i = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic [NB-1:0] busy_i = '0;
    logic clr_busy_i = 1'b0;
    logic ts_ext_i = 1'b0;
    logic ts_sel_ext_i = 1'b0;
    logic scaler_clr_i = 1'b0;
    logic raw_trig_o, live_trig_o, busy_o, ts_clk_o, pulse_free_o, pulse_veto_o;
    logic [NS*W-1:0] cnt_src_o;
    logic [W-1:0] cnt_raw_o, cnt_live_o, cnt_pfree_o, cnt_pveto_o;

    int n_vec = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit exp_q[$];

    always #2 clk = ~clk;

    trig_gate_top #(.N_SRC(NS), .N_BUSY(NB), .CNT_W(W), .TS_DIV(4), .PULSE_DIV(PD)) i_trig_gate_top (
        .clk(clk), .rst_n(rst_n), .clr_mod_i(clr_mod_i), .src_i(src_i), .busy_i(busy_i),
        .clr_busy_i(clr_busy_i), .ts_ext_i(ts_ext_i), .ts_sel_ext_i(ts_sel_ext_i),
        .scaler_clr_i(scaler_clr_i), .raw_trig_o(raw_trig_o), .live_trig_o(live_trig_o),
        .busy_o(busy_o), .ts_clk_o(ts_clk_o), .pulse_free_o(pulse_free_o),
        .pulse_veto_o(pulse_veto_o), .cnt_src_o(cnt_src_o), .cnt_raw_o(cnt_raw_o),
        .cnt_live_o(cnt_live_o), .cnt_pfree_o(cnt_pfree_o), .cnt_pveto_o(cnt_pveto_o));

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one source pulse, expected live decision pushed to the scoreboard
    task automatic fire(input int idx, input bit exp_live, input int hold);
        exp_q.push_back(exp_live);
        src_i[idx] = 1'b1;
        cyc(hold);
        src_i[idx] = 1'b0;
        cyc(4);
    endtask

    task automatic clear_busy;
        clr_busy_i = 1'b1;
        cyc(3);
        clr_busy_i = 1'b0;
        cyc(4);
    endtask

    function automatic int src_cnt(input int i);
        return int'(cnt_src_o[i*W +: W]);
    endfunction

    // monitor: every raw trigger pops one expectation and compares the live decision
    always @(negedge clk) begin
        if (rst_n && raw_trig_o) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R1: actual unexpected raw trigger expected none");
            end else begin
                automatic bit e = exp_q.pop_front();
                if (live_trig_o != e) begin
                    n_err++;
                    $display("FAIL R1/R2: actual live %0d expected %0d", live_trig_o, e);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        bit v [12];
        int f1, v1;
        bit held;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // reset state (R4)
        chk("R4 reset busy", busy_o, 0);
        chk("R4 reset raw", cnt_raw_o, 0);
        chk("R4 reset live", cnt_live_o, 0);

        // R1 R2: accept then reject while busy
        fire(0, 1'b1, 3);
        chk("R2 busy after live", busy_o, 1);
        fire(1, 1'b0, 3);
        chk("R2 still busy", busy_o, 1);
        clear_busy();
        chk("R3 busy released", busy_o, 0);
        fire(2, 1'b1, 3);
        clear_busy();
        // R11: a single partner busy line vetoes
        busy_i[4] = 1'b1;
        cyc(5);
        fire(3, 1'b0, 3);
        chk("R11 no busy latch under partner veto", busy_o, 0);
        busy_i[4] = 1'b0;
        cyc(5);
        chk("R8 raw count", cnt_raw_o, 4);
        chk("R8 live count", cnt_live_o, 2);
        for (int i = 0; i < NS; i++) chk("R8 source count", src_cnt(i), 1);

        // R8: long pulse counts once
        fire(0, 1'b1, 40);
        chk("R8 long pulse once", src_cnt(0), 2);
        clear_busy();
        // R3: clear and trigger on the same cycle, clear wins
        fire(1, 1'b1, 3);
        exp_q.push_back(1'b0);
        src_i[0] = 1'b1;
        clr_busy_i = 1'b1;
        cyc(3);
        src_i[0] = 1'b0;
        clr_busy_i = 1'b0;
        cyc(4);
        chk("R3 clear wins", busy_o, 0);
        chk("R8 raw total", cnt_raw_o, 7);
        chk("R8 live total", cnt_live_o, 4);
        chk("R1 scoreboard drained", exp_q.size(), 0);

        // R5: internal time stamp, period 4, half 2
        cyc(3);
        for (int i = 0; i < 12; i++) begin
            v[i] = ts_clk_o;
            cyc(1);
        end
        for (int i = 0; i < 10; i++) chk("R5 ts half period", int'(v[i+2] != v[i]), 1);
        busy_i[1] = 1'b1;
        cyc(4);
        held = ts_clk_o;
        for (int i = 0; i < 10; i++) begin
            cyc(2);
            chk("R5 ts held under veto", ts_clk_o, held);
        end
        busy_i[1] = 1'b0;
        cyc(4);

        // R6: external clock selection
        ts_sel_ext_i = 1'b1;
        ts_ext_i = 1'b1;
        cyc(4);
        chk("R6 ext high", ts_clk_o, 1);
        ts_ext_i = 1'b0;
        cyc(4);
        chk("R6 ext low", ts_clk_o, 0);
        busy_i[0] = 1'b1;
        cyc(4);
        ts_ext_i = 1'b1;
        cyc(6);
        chk("R6 ext held under veto", ts_clk_o, 0);
        busy_i[0] = 1'b0;
        cyc(4);
        chk("R6 ext resumes", ts_clk_o, 1);
        ts_sel_ext_i = 1'b0;

        // R7: pulsers
        scaler_clr_i = 1'b1;
        cyc(1);
        scaler_clr_i = 1'b0;
        cyc(PD * 5);
        chk("R7 free equals vetoed when idle", cnt_pveto_o, cnt_pfree_o);
        busy_i[3] = 1'b1;
        cyc(4);
        f1 = cnt_pfree_o;
        v1 = cnt_pveto_o;
        cyc(PD * 5);
        chk("R7 free pulser runs", cnt_pfree_o - f1, 5);
        chk("R7 vetoed pulser stops", cnt_pveto_o, v1);
        busy_i[3] = 1'b0;
        cyc(4);

        // R4: clear-module
        fire(2, 1'b1, 3);
        chk("R4 busy before clear", busy_o, 1);
        clr_mod_i = 1'b1;
        cyc(3);
        clr_mod_i = 1'b0;
        cyc(1);
        chk("R4 busy cleared", busy_o, 0);
        chk("R4 raw cleared", cnt_raw_o, 0);
        chk("R4 source cleared", src_cnt(2), 0);
        cyc(3);

        // R10: synchronous scaler clear
        fire(3, 1'b1, 3);
        clear_busy();
        scaler_clr_i = 1'b1;
        cyc(2);
        chk("R10 raw", cnt_raw_o, 0);
        chk("R10 live", cnt_live_o, 0);
        chk("R10 source", src_cnt(3), 0);
        chk("R10 pfree", cnt_pfree_o, 0);
        chk("R10 pveto", cnt_pveto_o, 0);
        scaler_clr_i = 1'b0;

        // R9: saturation with triggers vetoed by a partner
        busy_i[0] = 1'b1;
        cyc(4);
        for (int i = 0; i < 260; i++) fire(0, 1'b0, 2);
        chk("R9 raw saturates", cnt_raw_o, 255);
        chk("R9 source saturates", src_cnt(0), 255);
        chk("R9 live untouched", cnt_live_o, 0);
        busy_i[0] = 1'b0;
        cyc(4);
        chk("R1 scoreboard final", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule